// File: doc/BRIEF.md
# Memory Bandwidth QoS Monitor

This block measures memory controller traffic over one measurement window at a time. Software starts a window with a start strobe. The window is timed in one of two ways: a down-counting clock timer sets its length, or two successive rising edges of a video vsync input bound it. While the window is open, three counters advance. The first counts cycles in which any channel presents a request. The second counts cycles in which any channel is granted a data beat, one count per 64-bit data unit. The third counts granted beats from a single chosen channel, and only when the port ID on that channel is enabled in a port bitmask.

The busy output stays high from the cycle after an accepted start until the window closes, and then drops without any software action. An interrupt flag rises when the window closes. The three results then hold their values until software clears them or starts the next window. Channel select, port mask, trigger source and timer length are captured when a start is accepted, so later changes on those inputs do not affect a window that is already running.

Top module: `bw_qos_monitor`

## Requirements
- R1: A start strobe sampled while idle sets busy_o in the next cycle, zeroes all three counters, drops irq_o, and captures chan_sel_i, port_mask_i, trig_vsync_i and timer_len_i.
- R2: With trig_vsync_i = 0 the window spans exactly L clock edges after the start edge, where L is timer_len_i (a length of 0 is treated as 1). busy_o is low after the last of those edges.
- R3: With trig_vsync_i = 1 the block waits without counting until the first vsync_i rising edge after start. It counts from the next cycle up to and including the cycle of the following vsync_i rising edge, so a vsync period of P cycles adds P to the request counter when a request is present every cycle.
- R4: irq_o rises in the same cycle that busy_o falls at window close. It stays high until a clear or an accepted start, and it is never high while busy_o is high.
- R5: A clear_i strobe zeroes all three counters at the next edge, with priority over any increment in that cycle. It also drops irq_o, unless a window closes in that same cycle.
- R6: req_cnt_o adds one for each in-window cycle in which at least one bit of chan_req_i is high.
- R7: grant_cnt_o adds one for each in-window cycle in which at least one bit of chan_gnt_i is high.
- R8: sel_cnt_o adds one for each in-window cycle in which the selected channel's grant bit is high and the port mask bit indexed by that channel's port ID is high. Channel c's port ID sits at chan_port_i[c*PID_W +: PID_W]. sel_cnt_o never exceeds grant_cnt_o.
- R9: Every counter saturates at its all-ones value instead of wrapping.
- R10: After a window closes, all counters hold their values whatever traffic arrives, until the next start or clear.
- R11: A start strobe that arrives while busy_o is high is ignored. The running window keeps its length, configuration and counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe (one cycle) |
| clear_i | input | 1 | Clear results and interrupt (one cycle) |
| trig_vsync_i | input | 1 | Window source: 1 = vsync, 0 = timer |
| chan_sel_i | input | CSEL_W | Monitored channel index |
| port_mask_i | input | NUM_PORT | Port enable bitmask for the monitored channel |
| timer_len_i | input | TMR_W | Window length in cycles for timer mode |
| vsync_i | input | 1 | Video vsync level |
| chan_req_i | input | NUM_CHAN | Per-channel request strobe |
| chan_gnt_i | input | NUM_CHAN | Per-channel data grant strobe (one 64-bit unit) |
| chan_port_i | input | NUM_CHAN*PID_W | Per-channel port ID of the current grant |
| busy_o | output | 1 | Measurement in progress (start bit readback) |
| irq_o | output | 1 | Window-complete interrupt flag |
| req_cnt_o | output | CNT_W | Cycles with any request |
| grant_cnt_o | output | CNT_W | Cycles with any grant |
| sel_cnt_o | output | CNT_W | Grant cycles of the selected channel and ports |

## Verification
The bench runs a timer window for every channel select combined with every port mask of a four-channel, four-port build, using pseudo-random traffic. Any error in the port-ID slicing or mask indexing would therefore show up as a wrong selected count for some combination. The two window edges are checked cycle-exactly in both modes. An off-by-one in the timer, or counting during the wait before the first vsync, changes the totals by at least one. A six-bit counter build is driven past its limit: a wrapping counter would read a small value instead of 63. Traffic after completion must leave the frozen results unchanged. A second start issued mid-window must neither stretch the window nor reset the counts.

// File: rtl/bw_mon_pkg.sv
package bw_mon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } mon_state_e;

  localparam int unsigned NUM_CNT = 3;
  localparam int unsigned CNT_REQ = 0;
  localparam int unsigned CNT_GNT = 1;
  localparam int unsigned CNT_SEL = 2;

  function automatic int unsigned idx_w(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mon_window_fsm.sv
module mon_window_fsm
  import bw_mon_pkg::*;
#(
  parameter int unsigned TMR_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             trig_vsync_i,
  input  logic [TMR_W-1:0] timer_len_i,
  input  logic             vsync_i,
  output logic             launch_o,
  output logic             window_o,
  output logic             done_o,
  output logic             busy_o
);

  mon_state_e       state_q, state_d;
  logic [TMR_W-1:0] tmr_q;
  logic             vmode_q;
  logic             vs_q;
  logic             vs_rise;

  assign vs_rise = vsync_i & ~vs_q;

  always_comb begin
    state_d  = state_q;
    launch_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        launch_o = 1'b1;
        state_d  = trig_vsync_i ? ST_ARM : ST_RUN;
      end
      ST_ARM:  if (vs_rise) state_d = ST_RUN;
      ST_RUN:  if (vmode_q ? vs_rise : (tmr_q <= TMR_W'(1))) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign window_o = (state_q == ST_RUN);
  assign done_o   = window_o && (state_d == ST_IDLE);
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      vmode_q <= 1'b0;
      vs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      vs_q    <= vsync_i;
      if (launch_o) begin
        tmr_q   <= timer_len_i;
        vmode_q <= trig_vsync_i;
      end else if (window_o && tmr_q != '0) begin
        tmr_q <= tmr_q - TMR_W'(1);
      end
    end
  end

endmodule

// File: rtl/mon_port_filter.sv
module mon_port_filter
  import bw_mon_pkg::*;
#(
  parameter  int unsigned NUM_CHAN = 16,
  parameter  int unsigned NUM_PORT = 16,
  localparam int unsigned CSEL_W   = idx_w(NUM_CHAN),
  localparam int unsigned PID_W    = idx_w(NUM_PORT)
) (
  input  logic [CSEL_W-1:0]         chan_sel_i,
  input  logic [NUM_PORT-1:0]       port_mask_i,
  input  logic [NUM_CHAN-1:0]       chan_gnt_i,
  input  logic [NUM_CHAN*PID_W-1:0] chan_port_i,
  output logic                      hit_o
);

  localparam int unsigned MASK_EXT_W = 1 << PID_W;

  logic [MASK_EXT_W-1:0] mask_ext;
  logic [NUM_CHAN-1:0]   hit_vec;

  // unused port IDs map to zero mask bits
  assign mask_ext = MASK_EXT_W'(port_mask_i);

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic [PID_W-1:0] pid;
    assign pid        = chan_port_i[c*PID_W +: PID_W];
    assign hit_vec[c] = chan_gnt_i[c] && (chan_sel_i == CSEL_W'(c)) && mask_ext[pid];
  end

  assign hit_o = |hit_vec;

endmodule

// File: rtl/mon_sat_cnt.sv
module mon_sat_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (inc_i && ~&cnt_o)     cnt_o <= cnt_o + CNT_W'(1);
  end

endmodule

// File: rtl/bw_qos_monitor.sv
module bw_qos_monitor
  import bw_mon_pkg::*;
#(
  parameter  int unsigned NUM_CHAN = 16,
  parameter  int unsigned NUM_PORT = 16,
  parameter  int unsigned CNT_W    = 32,
  parameter  int unsigned TMR_W    = 32,
  localparam int unsigned CSEL_W   = idx_w(NUM_CHAN),
  localparam int unsigned PID_W    = idx_w(NUM_PORT)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic                      clear_i,
  input  logic                      trig_vsync_i,
  input  logic [CSEL_W-1:0]         chan_sel_i,
  input  logic [NUM_PORT-1:0]       port_mask_i,
  input  logic [TMR_W-1:0]          timer_len_i,
  input  logic                      vsync_i,
  input  logic [NUM_CHAN-1:0]       chan_req_i,
  input  logic [NUM_CHAN-1:0]       chan_gnt_i,
  input  logic [NUM_CHAN*PID_W-1:0] chan_port_i,
  output logic                      busy_o,
  output logic                      irq_o,
  output logic [CNT_W-1:0]          req_cnt_o,
  output logic [CNT_W-1:0]          grant_cnt_o,
  output logic [CNT_W-1:0]          sel_cnt_o
);

  logic                launch, window, done;
  logic [CSEL_W-1:0]   sel_q;
  logic [NUM_PORT-1:0] mask_q;
  logic                sel_hit;
  logic [NUM_CNT-1:0]  inc;
  logic [CNT_W-1:0]    cnt [NUM_CNT];

  mon_window_fsm #(.TMR_W(TMR_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .trig_vsync_i (trig_vsync_i),
    .timer_len_i  (timer_len_i),
    .vsync_i      (vsync_i),
    .launch_o     (launch),
    .window_o     (window),
    .done_o       (done),
    .busy_o       (busy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      mask_q <= '0;
    end else if (launch) begin
      sel_q  <= chan_sel_i;
      mask_q <= port_mask_i;
    end
  end

  mon_port_filter #(.NUM_CHAN(NUM_CHAN), .NUM_PORT(NUM_PORT)) u_filt (
    .chan_sel_i  (sel_q),
    .port_mask_i (mask_q),
    .chan_gnt_i  (chan_gnt_i),
    .chan_port_i (chan_port_i),
    .hit_o       (sel_hit)
  );

  assign inc[CNT_REQ] = window && (|chan_req_i);
  assign inc[CNT_GNT] = window && (|chan_gnt_i);
  assign inc[CNT_SEL] = window && sel_hit;

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    mon_sat_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (launch | clear_i),
      .inc_i  (inc[g]),
      .cnt_o  (cnt[g])
    );
  end

  assign req_cnt_o   = cnt[CNT_REQ];
  assign grant_cnt_o = cnt[CNT_GNT];
  assign sel_cnt_o   = cnt[CNT_SEL];

  // completion wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      irq_o <= 1'b0;
    else if (launch)  irq_o <= 1'b0;
    else if (done)    irq_o <= 1'b1;
    else if (clear_i) irq_o <= 1'b0;
  end

endmodule

// File: rtl/bw_qos_monitor_chk.sv
module bw_qos_monitor_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             clear_i,
  input logic             busy_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] req_cnt_o,
  input logic [CNT_W-1:0] grant_cnt_o,
  input logic [CNT_W-1:0] sel_cnt_o
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  p_start_busy_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && !irq_o && req_cnt_o == '0 && grant_cnt_o == '0 && sel_cnt_o == '0);

  p_done_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> irq_o);

  p_busy_no_irq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !irq_o);

  p_clear_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> req_cnt_o == '0 && grant_cnt_o == '0 && sel_cnt_o == '0);

  p_req_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) && !$past(clear_i) |->
      (req_cnt_o == $past(req_cnt_o)) || (req_cnt_o == $past(req_cnt_o) + CNT_W'(1)));

  p_gnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(start_i) && !$past(clear_i) |->
      (grant_cnt_o == $past(grant_cnt_o)) || (grant_cnt_o == $past(grant_cnt_o) + CNT_W'(1)));

  p_sel_le_gnt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_cnt_o <= grant_cnt_o);

  p_no_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(req_cnt_o) == CMAX && !$past(start_i) && !$past(clear_i) |-> req_cnt_o == CMAX);

  p_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_o) && !$past(start_i) && !$past(clear_i) |->
      $stable(req_cnt_o) && $stable(grant_cnt_o) && $stable(sel_cnt_o));

endmodule

bind bw_qos_monitor bw_qos_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .clear_i     (clear_i),
  .busy_o      (busy_o),
  .irq_o       (irq_o),
  .req_cnt_o   (req_cnt_o),
  .grant_cnt_o (grant_cnt_o),
  .sel_cnt_o   (sel_cnt_o)
);

// File: tb/bw_qos_monitor_tb_top.sv
module bw_qos_monitor_tb_top;

  localparam time         CLK_PERIOD = 10ns;
  localparam int unsigned NCH   = 4;
  localparam int unsigned NPT   = 4;
  localparam int unsigned PW    = 2;
  localparam int unsigned CW    = 6;
  localparam int unsigned TW    = 8;
  localparam int          CMAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, clear = 1'b0, trig = 1'b0, vsync = 1'b0;
  logic [1:0]    csel = '0;
  logic [NPT-1:0] pmask = '0;
  logic [TW-1:0] tlen = '0;
  logic [NCH-1:0] req = '0, gnt = '0;
  logic [NCH*PW-1:0] port = '0;
  logic          busy, irq;
  logic [CW-1:0] rc, gc, sc;

  int n_chk = 0, n_fail = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  bw_qos_monitor #(.NUM_CHAN(NCH), .NUM_PORT(NPT), .CNT_W(CW), .TMR_W(TW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .clear_i (clear),
    .trig_vsync_i (trig), .chan_sel_i (csel), .port_mask_i (pmask),
    .timer_len_i (tlen), .vsync_i (vsync), .chan_req_i (req), .chan_gnt_i (gnt),
    .chan_port_i (port), .busy_o (busy), .irq_o (irq),
    .req_cnt_o (rc), .grant_cnt_o (gc), .sel_cnt_o (sc)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > CMAXV) ? CMAXV : v;
  endfunction

  task automatic step_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  // launch a window at the next edge; returns at the negedge after it
  task automatic launch(input logic vmode, input int ch, input int m, input int len);
    trig = vmode; csel = 2'(ch); pmask = 4'(m); tlen = 8'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // timer window with random traffic, ncyc edges expected in the window
  task automatic run_random(input int ch, input int m, input int len, input int ncyc);
    int er = 0, eg = 0, es = 0;
    launch(1'b0, ch, m, len);
    check("R1 busy after start", int'(busy), 1);
    check("R1 irq dropped", int'(irq), 0);
    check("R1 req zeroed", int'(rc), 0);
    for (int k = 0; k < ncyc; k++) begin
      step_rng();
      req  = rng[3:0];
      gnt  = rng[7:4] & rng[19:16];
      port = rng[15:8];
      if (|req) er++;
      if (|gnt) eg++;
      if (gnt[ch] && m[port[ch*PW +: PW]]) es++;
      @(negedge clk);
    end
    req = '0; gnt = '0; port = '0;
    check("R2 busy low at end", int'(busy), 0);
    check("R4 irq at end", int'(irq), 1);
    check("R6 req count", int'(rc), sat(er));
    check("R7 grant count", int'(gc), sat(eg));
    check("R8 selected count", int'(sc), sat(es));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 reset busy", int'(busy), 0);
    check("R4 reset irq", int'(irq), 0);
    check("R1 reset req", int'(rc), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 sweep: every channel x every port mask
    for (int ch = 0; ch < int'(NCH); ch++)
      for (int m = 0; m < (1 << NPT); m++)
        run_random(ch, m, 20, 20);

    // R2 zero length acts as one cycle
    run_random(2, 15, 0, 1);
    run_random(1, 5, 1, 1);

    // R9 saturation with request and grant on every cycle
    req = '1; gnt = '1; port = '0;
    launch(1'b0, 0, 1, 100);
    repeat (99) @(negedge clk);
    check("R2 busy on last cycle", int'(busy), 1);
    @(negedge clk);
    check("R9 req saturates", int'(rc), CMAXV);
    check("R9 grant saturates", int'(gc), CMAXV);
    check("R9 sel saturates", int'(sc), CMAXV);
    check("R2 busy low after 100", int'(busy), 0);

    // R10 traffic after completion leaves results frozen
    repeat (6) @(negedge clk);
    check("R10 req frozen", int'(rc), CMAXV);
    check("R10 grant frozen", int'(gc), CMAXV);
    check("R4 irq held", int'(irq), 1);

    // R5 clear
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    check("R5 req cleared", int'(rc), 0);
    check("R5 sel cleared", int'(sc), 0);
    check("R5 irq cleared", int'(irq), 0);
    @(negedge clk);
    check("R10 stays zero after clear", int'(gc), 0);

    // R11 start mid-window ignored
    gnt = '0;
    launch(1'b0, 0, 1, 10);
    @(negedge clk);
    @(negedge clk);
    tlen = 8'd40; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (7) @(negedge clk);
    check("R11 window length kept", int'(busy), 0);
    check("R11 count not reset", int'(rc), 10);

    // R3 vsync window, period 12, requests every cycle
    launch(1'b1, 0, 1, 3);
    check("R3 armed busy", int'(busy), 1);
    repeat (5) @(negedge clk);
    check("R3 no count before vsync", int'(rc), 0);
    check("R3 still armed", int'(busy), 1);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    repeat (11) @(negedge clk);
    check("R3 open mid window", int'(busy), 1);
    vsync = 1'b1;
    @(negedge clk);
    vsync = 1'b0;
    check("R3 closed on second edge", int'(busy), 0);
    check("R3 one vsync period counted", int'(rc), 12);
    check("R4 irq after vsync window", int'(irq), 1);
    req = '0;

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule